// File: doc/BRIEF.md
# Masked-Access General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port. It sits behind a simple memory-mapped register bus with an address, a write strobe, write data and registered read data. Software sets each pin's direction, pull-up, analog select and digital enable. It can also hand a pin over to a peripheral, which then supplies the pin's output value and output enable. Pad inputs pass through a two-flop synchronizer before software can read them.

The data register is reached through a window of 256 word addresses. Address bits [9:2] act as a per-pin mask. A read returns only the selected pins and a write changes only the selected pins, so firmware can update single pins with no read-modify-write sequence. A commit register controls which pins may have their peripheral-select, pull-up and digital-enable bits changed.

Top module: `masked_gpio_port`

## Requirements
- R1: After reset, every register reads 0x00 except the commit register, which reads 0xFF. All pad output enables are 0.
- R2: A read at byte offset 0x000–0x3FC takes its mask from address bits [9:2], where pin n is selected by 0x004 << n. It returns the port value with every unselected pin forced to 0. With the port at 0x4C, offset 0x030 reads 0x0C. Read data appears one clock after the address is presented.
- R3: A write in the data window updates only the selected data bits and leaves the others unchanged. Writing 0x04 at offset 0x030 to a port holding 0x4C leaves 0x44.
- R4: Offset 0x3FC selects all eight pins, which gives full-width read and write of the data register.
- R5: The direction register is at offset 0x400 (0 = input, 1 = output). An output pin that is digitally enabled and not under peripheral control drives its data bit on pad_out with pad_oe high. A data read of an output pin returns the stored data bit.
- R6: The peripheral-select register is at offset 0x420. Where a bit is 1, pad_out and pad_oe for that pin come from periph_out and periph_oe.
- R7: The commit register is at offset 0x524 and can always be written. Writes to peripheral-select (0x420), pull-up (0x510) and digital-enable (0x51C) change only the bits whose commit bit is 1.
- R8: A pin whose digital-enable bit is 0 drives no output (pad_oe = 0). If it is an input, its data read is 0.
- R9: A data read of an input pin returns pad_in through two synchronizer flops. A pad change is not visible to a read issued at the first or second clock after the change, and is visible to a read issued at the third clock.
- R10: A read of an unmapped offset returns 0, and a write to it changes no register.
- R11: The pull-up register at 0x510 and the analog-select register at 0x528 drive pad_pull and pad_ana directly. The analog-select register is not gated by commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address; bits [1:0] ignored |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pull | output | 8 | Pull-up enables |
| pad_ana | output | 8 | Analog mode selects |
| periph_out | input | 8 | Peripheral output values |
| periph_oe | input | 8 | Peripheral output enables |

## Verification
The assertions assume that bus_addr and bus_wdata are stable around each clock edge. The synchronizer check assumes pad_in is sampled cleanly, without metastability, so that the flop chain behaves as an exact two-cycle delay. The stimulus changes pad_in only between edges and then waits three clocks before it relies on the new value. Random addresses are drawn both from mapped offsets and from a set of unmapped ones. Bus writes and pad changes never overlap.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned OFS_DIR    = 'h400;
  localparam int unsigned OFS_ALT    = 'h420;
  localparam int unsigned OFS_PULL   = 'h510;
  localparam int unsigned OFS_DEN    = 'h51C;
  localparam int unsigned OFS_COMMIT = 'h524;
  localparam int unsigned OFS_ANA    = 'h528;
  localparam int unsigned OFS_FULL   = 'h3FC;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DATA, SEL_DIR, SEL_ALT, SEL_PULL, SEL_DEN, SEL_COMMIT, SEL_ANA
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  // R9
  sync_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  in_sync,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  alt_q,
  output logic [WIDTH-1:0]  pull_q,
  output logic [WIDTH-1:0]  den_q,
  output logic [WIDTH-1:0]  commit_q,
  output logic [WIDTH-1:0]  ana_q
);
  localparam int MASK_LSB = 2;
  localparam int WIN_MSB  = WIDTH + MASK_LSB;

  logic [ADDR_W-1:0] word;
  logic [WIDTH-1:0]  mask;
  logic              in_window;
  reg_sel_e          sel;
  logic [WIDTH-1:0]  port_val;
  logic [WIDTH-1:0]  rd_next;

  always_comb begin
    word      = {addr[ADDR_W-1:2], 2'b00};
    mask      = addr[MASK_LSB +: WIDTH];
    in_window = (addr[ADDR_W-1:WIN_MSB] == '0);
    if (in_window)                         sel = SEL_DATA;
    else if (word == ADDR_W'(OFS_DIR))     sel = SEL_DIR;
    else if (word == ADDR_W'(OFS_ALT))     sel = SEL_ALT;
    else if (word == ADDR_W'(OFS_PULL))    sel = SEL_PULL;
    else if (word == ADDR_W'(OFS_DEN))     sel = SEL_DEN;
    else if (word == ADDR_W'(OFS_COMMIT))  sel = SEL_COMMIT;
    else if (word == ADDR_W'(OFS_ANA))     sel = SEL_ANA;
    else                                   sel = SEL_NONE;
  end

  always_comb begin
    port_val = (dir_q & data_q) | (~dir_q & in_sync & den_q);
    unique case (sel)
      SEL_DATA:   rd_next = port_val & mask;
      SEL_DIR:    rd_next = dir_q;
      SEL_ALT:    rd_next = alt_q;
      SEL_PULL:   rd_next = pull_q;
      SEL_DEN:    rd_next = den_q;
      SEL_COMMIT: rd_next = commit_q;
      SEL_ANA:    rd_next = ana_q;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      data_q   <= '0;
      dir_q    <= '0;
      alt_q    <= '0;
      pull_q   <= '0;
      den_q    <= '0;
      commit_q <= '1;
      ana_q    <= '0;
    end else begin
      rdata <= rd_next;
      if (we) begin
        unique case (sel)
          SEL_DATA:   data_q   <= (data_q & ~mask) | (wdata & mask);
          SEL_DIR:    dir_q    <= wdata;
          SEL_ALT:    alt_q    <= (alt_q  & ~commit_q) | (wdata & commit_q);
          SEL_PULL:   pull_q   <= (pull_q & ~commit_q) | (wdata & commit_q);
          SEL_DEN:    den_q    <= (den_q  & ~commit_q) | (wdata & commit_q);
          SEL_COMMIT: commit_q <= wdata;
          SEL_ANA:    ana_q    <= wdata;
          default:    ;
        endcase
      end
    end
  end

  // R3
  unmasked_data_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ((data_q ^ $past(data_q)) & ~($past(we && in_window) ? $past(mask) : '0)) == '0);

  // R4
  full_window_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && word == ADDR_W'(OFS_FULL)) |=> (data_q == $past(wdata)));

  // R7
  commit_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (((alt_q ^ $past(alt_q)) | (pull_q ^ $past(pull_q)) | (den_q ^ $past(den_q)))
      & ~$past(commit_q)) == '0);

  // R10
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (rdata == '0));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] alt_q,
  input  logic [WIDTH-1:0] den_q,
  input  logic [WIDTH-1:0] periph_out,
  input  logic [WIDTH-1:0] periph_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      pad_out[i] = alt_q[i] ? periph_out[i] : data_q[i];
      pad_oe[i]  = den_q[i] & (alt_q[i] ? periph_oe[i] : dir_q[i]);
    end
  end
endmodule

// File: rtl/masked_gpio_port.sv
module masked_gpio_port #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pull,
  output logic [WIDTH-1:0]  pad_ana,
  input  logic [WIDTH-1:0]  periph_out,
  input  logic [WIDTH-1:0]  periph_oe
);
  logic [WIDTH-1:0] in_sync, data_q, dir_q, alt_q, den_q, commit_q;

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(in_sync)
  );

  gpio_regfile #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .in_sync(in_sync), .rdata(bus_rdata), .data_q(data_q), .dir_q(dir_q),
    .alt_q(alt_q), .pull_q(pad_pull), .den_q(den_q), .commit_q(commit_q),
    .ana_q(pad_ana)
  );

  gpio_pad_mux #(.WIDTH(WIDTH)) u_mux (
    .data_q(data_q), .dir_q(dir_q), .alt_q(alt_q), .den_q(den_q),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: tb/test_masked_gpio_port.sv
`timescale 1ns/1ps
module test_masked_gpio_port;
  logic        clk = 0;
  logic        rst = 1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out, pad_oe, pad_pull, pad_ana;
  logic [7:0]  periph_out = '0, periph_oe = '0;

  always #2.5 clk = ~clk;

  masked_gpio_port i_masked_gpio_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull), .pad_ana(pad_ana),
    .periph_out(periph_out), .periph_oe(periph_oe)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_data = 0, m_dir = 0, m_alt = 0, m_pull = 0, m_den = 0, m_cr = 8'hFF, m_ana = 0;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [11:0] a);
    logic [11:0] w = {a[11:2], 2'b00};
    if (a[11:10] == 2'b00)
      return ((m_dir & m_data) | (~m_dir & pad_in & m_den)) & a[9:2];
    case (w)
      12'h400: return m_dir;
      12'h420: return m_alt;
      12'h510: return m_pull;
      12'h51C: return m_den;
      12'h524: return m_cr;
      12'h528: return m_ana;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(logic [11:0] a, logic [7:0] d);
    logic [11:0] w = {a[11:2], 2'b00};
    if (a[11:10] == 2'b00) m_data = (m_data & ~a[9:2]) | (d & a[9:2]);
    else case (w)
      12'h400: m_dir = d;
      12'h420: m_alt = (m_alt & ~m_cr) | (d & m_cr);
      12'h510: m_pull = (m_pull & ~m_cr) | (d & m_cr);
      12'h51C: m_den = (m_den & ~m_cr) | (d & m_cr);
      12'h524: m_cr = d;
      12'h528: m_ana = d;
      default: ;
    endcase
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1;
    bus_we = 0;
    model_write(a, d);
  endtask

  task automatic rd(logic [11:0] a, output logic [7:0] v);
    bus_addr = a; bus_we = 0;
    @(posedge clk); #1;
    v = bus_rdata;
  endtask

  task automatic rd_chk(string req, logic [11:0] a);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp_read(a));
  endtask

  task automatic pads_chk(string req);
    logic [7:0] eo, eoe;
    eo  = (m_alt & periph_out) | (~m_alt & m_data);
    eoe = m_den & ((m_alt & periph_oe) | (~m_alt & m_dir));
    chk({req, " pad_out"}, pad_out, eo);
    chk({req, " pad_oe"}, pad_oe, eoe);
    chk({req, " pad_pull"}, pad_pull, m_pull);
    chk({req, " pad_ana"}, pad_ana, m_ana);
  endtask

  task automatic set_pads(logic [7:0] v);
    pad_in = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  logic [11:0] mapped[7] = '{12'h400, 12'h420, 12'h510, 12'h51C, 12'h524, 12'h528, 12'h3FC};
  logic [11:0] unmapped[5] = '{12'h404, 12'h520, 12'h600, 12'hFFC, 12'h52C};

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1 reset state
    foreach (mapped[i]) rd_chk("R1 reset", mapped[i]);
    pads_chk("R1");

    // R2 R3 R4 R5 example pattern
    wr(12'h51C, 8'hFF);
    wr(12'h400, 8'hFF);
    wr(12'h3FC, 8'h4C);
    rd(12'h030, v); chk("R2 masked read", v, 8'h0C);
    rd(12'h3FC, v); chk("R4 full read", v, 8'h4C);
    wr(12'h030, 8'h04);
    rd(12'h3FC, v); chk("R3 masked write", v, 8'h44);
    pads_chk("R5");
    chk("R5 drive", pad_out, 8'h44);

    // R9 synchronizer latency, inputs on all pins
    wr(12'h400, 8'h00);
    wr(12'h3FC, 8'h00);
    set_pads(8'h00);
    pad_in = 8'hA5;
    rd(12'h3FC, v); chk("R9 first clock", v, 8'h00);
    rd(12'h3FC, v); chk("R9 second clock", v, 8'h00);
    rd(12'h3FC, v); chk("R9 third clock", v, 8'hA5);

    // R8 digital disable
    wr(12'h400, 8'h0F);
    wr(12'h51C, 8'h33);
    rd(12'h3FC, v); chk("R8 input reads zero", v, (8'h0F & m_data) | (8'hF0 & 8'hA5 & 8'h33));
    chk("R8 no drive", pad_oe, 8'h03);

    // R7 commit gating, R11 analog free
    wr(12'h524, 8'h0F);
    wr(12'h420, 8'hFF);
    rd(12'h420, v); chk("R7 alt gated", v, 8'h0F);
    wr(12'h510, 8'hFF);
    rd(12'h510, v); chk("R7 pull gated", v, 8'h0F);
    wr(12'h528, 8'hC3);
    rd(12'h528, v); chk("R11 ana free", v, 8'hC3);
    pads_chk("R11");

    // R6 peripheral takeover
    periph_out = 8'h5A; periph_oe = 8'hF0; #1;
    pads_chk("R6");

    // R10 unmapped
    wr(12'h600, 8'hFF);
    wr(12'h404, 8'hFF);
    rd(12'h600, v); chk("R10 unmapped read", v, 8'h00);
    foreach (mapped[i]) rd_chk("R10 no side effect", mapped[i]);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      logic [11:0] a;
      case ($urandom_range(0, 3))
        0: a = unmapped[$urandom_range(0, 4)];
        1: a = mapped[$urandom_range(0, 6)];
        default: a = {2'b00, 8'($urandom), 2'b00};
      endcase
      if (op < 4) wr(a, 8'($urandom));
      else if (op < 8) rd_chk("R2 R5 R7 R10 random read", a);
      else if (op == 8) set_pads(8'($urandom));
      else begin
        periph_out = 8'($urandom); periph_oe = 8'($urandom); #1;
      end
      pads_chk("R6 R8 random pads");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule